// File: doc/BRIEF.md
# Host Command Transaction Sequencer

This block runs one complete command exchange, from the host side, with a peripheral that sleeps between exchanges and talks over a single-wire token link. It does not make waveforms and does not compute checksums. It asks a lower-level token driver for each token: wake, transmit flag, command flag or sleep flag. It hands that driver the command block one byte index at a time. It watches the bytes the driver receives and judges the response from a CRC verdict that the driver supplies.

One start pulse latches the command length, a short-command option and two cycle-count delays, for parsing and execution. The sequencer wakes the peripheral and checks the wake synchronization byte. It then sends the command flag and block and waits the delays. A normal command gets a separate parse wait and a probe for an early error code before the execution wait. A short command gets one merged wait instead. The sequencer then reads the response block and re-reads it on a CRC failure, up to a set number of times. Whatever the outcome, it always puts the peripheral back to sleep before reporting done and a status code.

Top module: `cmd_xact_seq`

## Requirements
- R1: While reset is held and right after it is released: `busy`, `done`, `tok_req` and `tx_valid` are 0, and `status` is 0 (OK).
- R2: A token request holds `tok_req` high with a steady `tok_kind` until `tok_ack`. Codes: 0 wake, 1 transmit flag, 2 command flag, 3 sleep flag. Each exchange starts with wake followed by a transmit flag.
- R3: The byte received after that first transmit flag must be 0x11. Any other value ends the exchange with status 1 (sync failure), and no command flag is sent.
- R4: After a good sync byte, a command flag is requested. Then `tx_valid` offers `cmd_len` bytes with `tx_idx` counting 0 to `cmd_len`-1, advancing on each `tx_valid && tx_ready` edge.
- R5: For a normal command, the transmit-flag request rises `parse_dly`+1 clock edges after the edge that accepts the last command byte.
- R6: After the probe flag is acknowledged, a byte arriving within the next RX_TIMEOUT+1 cycles is an error code. The last cycle of that span counts. The code is reported on `err_code`, status becomes 3, and no further transmit flag is sent. If no byte arrives, the transmit-flag request for the response rises RX_TIMEOUT+`exec_dly`+2 edges after the acknowledging edge.
- R7: For a short command there is no probe. The transmit-flag request rises `parse_dly`+`exec_dly`+1 edges after the edge that accepts the last command byte.
- R8: The first response byte gives the total block length N, counting itself. The Nth byte ends the block, and `crc_ok` is sampled in the cycle of that byte. If `crc_ok` is true, status is 0.
- R9: A failed CRC triggers another transmit flag and a full re-read, at most MAX_RETRY times. After that the status is 4 (CRC failure).
- R10: An expected sync or response byte that does not arrive within RX_TIMEOUT+1 cycles of the token acknowledgement or the previous byte gives status 2 (timeout).
- R11: Every exchange, successful or not, ends with a sleep flag. `done` pulses for exactly one cycle on the edge after the sleep acknowledgement. `busy` is high from the edge after `start` until `done`, and `status` holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (honoured when idle) |
| cmd_len | input | LEN_W | Command block length in bytes |
| short_cmd | input | 1 | Use the merged delay path |
| parse_dly | input | DLY_W | Parse wait in cycles |
| exec_dly | input | DLY_W | Execution wait in cycles |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 OK, 1 sync, 2 timeout, 3 command error, 4 CRC |
| err_code | output | 8 | Error byte captured by the probe |
| tok_req | output | 1 | Token request to the token driver |
| tok_kind | output | 2 | Requested token code |
| tok_ack | input | 1 | Token driver accepted the request |
| tx_valid | output | 1 | A command byte is offered |
| tx_idx | output | LEN_W | Index of the offered command byte |
| tx_ready | input | 1 | Driver takes the offered byte |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| crc_ok | input | 1 | CRC verdict, valid with the final response byte |

## Verification
Two events can land in the same cycle: the early error byte in the probe window, and the expiry of that window. The bench delays the peripheral model's reply so that the byte reaches the sequencer exactly in the window's final cycle. The expected outcome there is a command error with the byte captured. A second run delays the reply by one more cycle. In that run the sequencer must already have moved to the execution wait, ignore the stray byte and finish with a good response.

// File: rtl/cmd_xact_pkg.sv
`timescale 1ns/1ps
package cmd_xact_pkg;

   typedef enum logic [1:0] {
      TOK_WAKE  = 2'd0,
      TOK_XMIT  = 2'd1,
      TOK_CMD   = 2'd2,
      TOK_SLEEP = 2'd3
   } tok_e;

   typedef enum logic [2:0] {
      XS_OK      = 3'd0,
      XS_SYNC    = 3'd1,
      XS_TIMEOUT = 3'd2,
      XS_CMDERR  = 3'd3,
      XS_CRC     = 3'd4
   } xstat_e;

   typedef enum logic [3:0] {
      S_IDLE, S_WAKE, S_XSYNC, S_WSYNC, S_CMDF, S_SEND, S_WPARSE,
      S_XPROBE, S_WPROBE, S_WEXEC, S_XRSP, S_RRSP, S_SLEEP, S_DONE
   } xstate_e;

   localparam logic [7:0] SYNC_BYTE = 8'h11;

endpackage

// File: rtl/cmd_xact_timer.sv
`timescale 1ns/1ps
module cmd_xact_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

   // R5: an expired timer stays expired until reloaded
   a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      zero && !load |=> zero);
   // R7: a load of a non-zero count is never seen as already expired
   a_r7_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
      load && (val != '0) |=> !zero);
endmodule

// File: rtl/cmd_xact_retry.sv
`timescale 1ns/1ps
module cmd_xact_retry #(
   parameter int MAX = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic room
);
   generate
      if (MAX == 0) begin : g_none
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, clr, inc};
         assign room = 1'b0;
      end else begin : g_cnt
         localparam int W = $clog2(MAX + 1);
         logic [W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (clr)  cnt <= '0;
            else if (inc)  cnt <= cnt + W'(1);
         end
         assign room = (cnt < W'(MAX));
         // R9: the sequencer never asks for a re-read beyond the cap
         a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
            inc |-> room);
      end
   endgenerate
endmodule

// File: rtl/cmd_xact_rxblk.sv
`timescale 1ns/1ps
module cmd_xact_rxblk (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       take,
   input  logic [7:0] data,
   output logic       last
);
   logic       first_q;
   logic [7:0] rem_q;

   assign last = first_q ? (data <= 8'd1) : (rem_q == 8'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         rem_q   <= '0;
      end else if (clr) begin
         first_q <= 1'b1;
      end else if (take) begin
         if (first_q) begin
            first_q <= 1'b0;
            rem_q   <= data - 8'd1;
         end else begin
            rem_q   <= rem_q - 8'd1;
         end
      end
   end

   // R8: no byte is taken after the block length has been used up
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      take && !first_q |-> rem_q != 8'd0);
endmodule

// File: rtl/cmd_xact_seq.sv
`timescale 1ns/1ps
module cmd_xact_seq
   import cmd_xact_pkg::*;
#(
   parameter int LEN_W      = 6,
   parameter int DLY_W      = 12,
   parameter int RX_TIMEOUT = 24,
   parameter int MAX_RETRY  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             short_cmd,
   input  logic [DLY_W-1:0] parse_dly,
   input  logic [DLY_W-1:0] exec_dly,
   output logic             busy,
   output logic             done,
   output logic [2:0]       status,
   output logic [7:0]       err_code,
   output logic             tok_req,
   output logic [1:0]       tok_kind,
   input  logic             tok_ack,
   output logic             tx_valid,
   output logic [LEN_W-1:0] tx_idx,
   input  logic             tx_ready,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             crc_ok
);
   localparam int SUM_W = DLY_W + 1;
   localparam int TO_W  = $clog2(RX_TIMEOUT + 1);

   generate
      if (LEN_W < 3)      begin : g_bad_len  $error("LEN_W too small");      end
      if (DLY_W < 1)      begin : g_bad_dly  $error("DLY_W must be >= 1");   end
      if (RX_TIMEOUT < 1) begin : g_bad_to   $error("RX_TIMEOUT must be >= 1"); end
      if (MAX_RETRY > 15) begin : g_bad_rty  $error("MAX_RETRY too large"); end
   endgenerate

   xstate_e          st, st_nx;
   logic [LEN_W-1:0] len_q, idx_q;
   logic             short_q;
   logic [DLY_W-1:0] pdly_q, edly_q;
   xstat_e           stat_q, stat_nx;
   logic [7:0]       errb_q;
   tok_e             tk;

   logic             launch, tok_go, tx_fire;
   logic             dly_load, dly_zero, to_load, to_zero;
   logic [SUM_W-1:0] dly_val;
   logic             rx_clr, rx_take, rx_last;
   logic             rty_inc, rty_room, set_stat, cap_errb;

   // ---------------- outputs decoded from state ----------------
   always_comb begin
      unique case (st)
         S_WAKE:  tk = TOK_WAKE;
         S_CMDF:  tk = TOK_CMD;
         S_SLEEP: tk = TOK_SLEEP;
         default: tk = TOK_XMIT;
      endcase
   end

   assign tok_req  = (st == S_WAKE) || (st == S_XSYNC) || (st == S_CMDF) ||
                     (st == S_XPROBE) || (st == S_XRSP) || (st == S_SLEEP);
   assign tok_kind = tk;
   assign tok_go   = tok_req && tok_ack;
   assign tx_valid = (st == S_SEND);
   assign tx_idx   = idx_q;
   assign tx_fire  = tx_valid && tx_ready;
   assign busy     = (st != S_IDLE);
   assign done     = (st == S_DONE);
   assign status   = stat_q;
   assign err_code = errb_q;
   assign launch   = (st == S_IDLE) && start;
   assign rx_take  = (st == S_RRSP) && rx_valid;

   // ---------------- next-state logic ----------------
   always_comb begin
      st_nx    = st;
      dly_load = 1'b0;
      dly_val  = '0;
      to_load  = 1'b0;
      rx_clr   = 1'b0;
      rty_inc  = 1'b0;
      set_stat = 1'b0;
      stat_nx  = XS_OK;
      cap_errb = 1'b0;
      unique case (st)
         S_IDLE:   if (start) st_nx = S_WAKE;
         S_WAKE:   if (tok_go) st_nx = S_XSYNC;
         S_XSYNC:  if (tok_go) begin st_nx = S_WSYNC; to_load = 1'b1; end
         S_WSYNC: begin
            if (rx_valid) begin
               if (rx_data == SYNC_BYTE) st_nx = S_CMDF;
               else begin
                  st_nx = S_SLEEP; set_stat = 1'b1; stat_nx = XS_SYNC;
               end
            end else if (to_zero) begin
               st_nx = S_SLEEP; set_stat = 1'b1; stat_nx = XS_TIMEOUT;
            end
         end
         S_CMDF:   if (tok_go) st_nx = S_SEND;
         S_SEND: begin
            if (tx_fire && (idx_q == len_q - LEN_W'(1))) begin
               dly_load = 1'b1;
               if (short_q) begin
                  st_nx   = S_WEXEC;
                  dly_val = {1'b0, pdly_q} + {1'b0, edly_q};
               end else begin
                  st_nx   = S_WPARSE;
                  dly_val = {1'b0, pdly_q};
               end
            end
         end
         S_WPARSE: if (dly_zero) st_nx = S_XPROBE;
         S_XPROBE: if (tok_go) begin st_nx = S_WPROBE; to_load = 1'b1; end
         S_WPROBE: begin
            // a byte present in the final window cycle wins over expiry
            if (rx_valid) begin
               st_nx = S_SLEEP; set_stat = 1'b1; stat_nx = XS_CMDERR;
               cap_errb = 1'b1;
            end else if (to_zero) begin
               st_nx = S_WEXEC; dly_load = 1'b1; dly_val = {1'b0, edly_q};
            end
         end
         S_WEXEC:  if (dly_zero) st_nx = S_XRSP;
         S_XRSP:   if (tok_go) begin st_nx = S_RRSP; to_load = 1'b1; rx_clr = 1'b1; end
         S_RRSP: begin
            if (rx_valid) begin
               to_load = 1'b1;
               if (rx_last) begin
                  if (crc_ok) begin
                     st_nx = S_SLEEP; set_stat = 1'b1; stat_nx = XS_OK;
                  end else if (rty_room) begin
                     st_nx = S_XRSP; rty_inc = 1'b1;
                  end else begin
                     st_nx = S_SLEEP; set_stat = 1'b1; stat_nx = XS_CRC;
                  end
               end
            end else if (to_zero) begin
               st_nx = S_SLEEP; set_stat = 1'b1; stat_nx = XS_TIMEOUT;
            end
         end
         S_SLEEP:  if (tok_go) st_nx = S_DONE;
         S_DONE:   st_nx = S_IDLE;
         default:  st_nx = S_IDLE;
      endcase
   end

   // ---------------- state and context registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         len_q   <= '0;
         idx_q   <= '0;
         short_q <= 1'b0;
         pdly_q  <= '0;
         edly_q  <= '0;
         stat_q  <= XS_OK;
         errb_q  <= '0;
      end else begin
         st <= st_nx;
         if (launch) begin
            len_q   <= cmd_len;
            short_q <= short_cmd;
            pdly_q  <= parse_dly;
            edly_q  <= exec_dly;
            idx_q   <= '0;
            stat_q  <= XS_OK;
            errb_q  <= '0;
         end else begin
            if (tx_fire)  idx_q  <= idx_q + LEN_W'(1);
            if (set_stat) stat_q <= stat_nx;
            if (cap_errb) errb_q <= rx_data;
         end
      end
   end

   // ---------------- helpers ----------------
   cmd_xact_timer #(.W(SUM_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .load(dly_load), .val(dly_val), .zero(dly_zero));

   cmd_xact_timer #(.W(TO_W)) u_to (
      .clk(clk), .rst_n(rst_n), .load(to_load), .val(TO_W'(RX_TIMEOUT)), .zero(to_zero));

   cmd_xact_retry #(.MAX(MAX_RETRY)) u_rty (
      .clk(clk), .rst_n(rst_n), .clr(launch), .inc(rty_inc), .room(rty_room));

   cmd_xact_rxblk u_blk (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .take(rx_take), .data(rx_data), .last(rx_last));

   // ---------------- assertions ----------------
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tok_req && !tok_ack |=> tok_req && $stable(tok_kind));
   a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tok_req, tx_valid}));
   a_r11_done_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(tok_req && tok_ack && (tok_kind == 2'd3)));
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_short_no_probe: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_XPROBE) |-> !short_q);
   a_r6_probe_code: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WPROBE) && rx_valid |=> (err_code == $past(rx_data)) && (status == 3'd3));
endmodule

// File: tb/cmd_xact_seq_test.sv
`timescale 1ns/1ps
module cmd_xact_seq_test;
   localparam int TO  = 24;
   localparam int RTY = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [5:0] cmd_len = '0;
   logic       short_cmd = 1'b0;
   logic [11:0] parse_dly = '0;
   logic [11:0] exec_dly = '0;
   logic       busy, done, tok_req, tx_valid;
   logic [2:0] status;
   logic [7:0] err_code;
   logic [1:0] tok_kind;
   logic [5:0] tx_idx;
   logic       tok_ack = 1'b0;
   logic       tx_ready = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       crc_ok = 1'b0;

   always #10 clk = ~clk;

   cmd_xact_seq #(.LEN_W(6), .DLY_W(12), .RX_TIMEOUT(TO), .MAX_RETRY(RTY)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .short_cmd(short_cmd),
      .parse_dly(parse_dly), .exec_dly(exec_dly), .busy(busy), .done(done),
      .status(status), .err_code(err_code), .tok_req(tok_req), .tok_kind(tok_kind),
      .tok_ack(tok_ack), .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .crc_ok(crc_ok));

   int n_run = 0, n_fail = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // peripheral model configuration
   bit         mode_short, sync_silent, probe_reply, rsp_silent, idx_bad;
   logic [7:0] sync_val, probe_val;
   int         probe_d, rsp_len, crc_bad, n_x, tx_cnt;
   int         last_tx_cyc, probe_cyc, rsp_cyc;
   string      tok_str;

   task automatic cfg_default();
      sync_val = 8'h11; sync_silent = 0; probe_reply = 0; probe_d = 2;
      probe_val = 8'h00; rsp_len = 4; rsp_silent = 0; crc_bad = 0;
   endtask

   function automatic string kch(logic [1:0] k);
      case (k)
         2'd0: return "W";
         2'd1: return "X";
         2'd2: return "C";
         default: return "S";
      endcase
   endfunction

   task automatic chk_i(string r, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   task automatic chk_s(string r, string what, string act, string exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %s expected %s", r, what, act, exp);
      end
   endtask

   task automatic send_byte(int d, logic [7:0] v, logic c);
      repeat (d) @(negedge clk);
      rx_valid = 1'b1; rx_data = v; crc_ok = c;
      @(negedge clk);
      rx_valid = 1'b0; crc_ok = 1'b0;
   endtask

   // command byte monitor; ready toggles so transfers stall
   always @(negedge clk) begin
      tx_ready = ~tx_ready;
      if (tx_valid && tx_ready) begin
         if (int'(tx_idx) != tx_cnt) idx_bad = 1;
         tx_cnt++;
         last_tx_cyc = cyc;
      end
   end

   // token driver and peripheral model
   initial begin
      logic [1:0] k;
      forever begin
         @(negedge clk);
         if (rst_n && tok_req && !tok_ack) begin
            k = tok_kind;
            tok_ack = 1'b1;
            tok_str = {tok_str, kch(k)};
            if (k == 2'd1) begin
               if (n_x == 1 && !mode_short) probe_cyc = cyc;
               else if (n_x == (mode_short ? 1 : 2)) rsp_cyc = cyc;
            end
            @(negedge clk);
            tok_ack = 1'b0;
            if (k == 2'd1) begin
               if (n_x == 0) begin
                  if (!sync_silent) send_byte(2, sync_val, 1'b0);
               end else if (n_x == 1 && !mode_short) begin
                  if (probe_reply) send_byte(probe_d, probe_val, 1'b0);
               end else if (!rsp_silent) begin
                  for (int i = 0; i < rsp_len; i++)
                     send_byte(2, (i == 0) ? 8'(rsp_len) : 8'(8'hA0 + i),
                               (i == rsp_len - 1) && (crc_bad == 0));
                  if (crc_bad > 0) crc_bad--;
               end
               n_x++;
            end
         end
      end
   end

   task automatic run(int len, bit sh, int p, int e, output bit got);
      @(negedge clk);
      n_x = 0; tok_str = ""; tx_cnt = 0; idx_bad = 0; mode_short = sh;
      last_tx_cyc = 0; probe_cyc = 0; rsp_cyc = 0;
      cmd_len = 6'(len); short_cmd = sh; parse_dly = 12'(p); exec_dly = 12'(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_i("R11", "busy after start", int'(busy), 1);
      got = 0;
      for (int i = 0; i < 4000 && !got; i++) begin
         @(negedge clk);
         if (done) got = 1;
      end
      chk_i("R11", "done pulse seen", int'(got), 1);
      @(negedge clk);
      chk_i("R11", "done lasts one cycle", int'(done), 0);
      chk_i("R11", "idle after done", int'(busy), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk_i("R1", "busy in reset", int'(busy), 0);
      chk_i("R1", "tok_req in reset", int'(tok_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_i("R1", "done after reset", int'(done), 0);
      chk_i("R1", "tx_valid after reset", int'(tx_valid), 0);
      chk_i("R1", "status after reset", int'(status), 0);
   endtask

   task automatic t_normal();
      bit g;
      cfg_default(); rsp_len = 7;
      run(5, 0, 7, 9, g);
      chk_s("R2", "token order", tok_str, "WXCXXS");
      chk_i("R4", "bytes sent", tx_cnt, 5);
      chk_i("R4", "index sequence broken", int'(idx_bad), 0);
      chk_i("R5", "parse gap", probe_cyc - last_tx_cyc, 7 + 2);
      chk_i("R6", "exec gap", rsp_cyc - probe_cyc, TO + 9 + 3);
      chk_i("R8", "status ok", int'(status), 0);
   endtask

   task automatic t_short();
      bit g;
      cfg_default();
      run(4, 1, 3, 6, g);
      chk_s("R7", "token order", tok_str, "WXCXS");
      chk_i("R7", "merged gap", rsp_cyc - last_tx_cyc, 3 + 6 + 2);
      chk_i("R8", "status ok", int'(status), 0);
   endtask

   task automatic t_badsync();
      bit g;
      cfg_default(); sync_val = 8'h12;
      run(4, 0, 2, 2, g);
      chk_s("R3", "token order", tok_str, "WXS");
      chk_i("R3", "status sync", int'(status), 1);
      chk_i("R3", "bytes sent", tx_cnt, 0);
   endtask

   task automatic t_probe_err();
      bit g;
      cfg_default(); probe_reply = 1; probe_val = 8'h0F;
      run(4, 0, 4, 5, g);
      chk_s("R6", "token order", tok_str, "WXCXS");
      chk_i("R6", "status cmd error", int'(status), 3);
      chk_i("R6", "error byte", int'(err_code), 'h0F);
   endtask

   task automatic t_probe_edge();
      bit g;
      cfg_default(); probe_reply = 1; probe_val = 8'h33; probe_d = TO;
      run(4, 0, 1, 3, g);
      chk_i("R6", "last window cycle is error", int'(status), 3);
      chk_i("R6", "error byte at edge", int'(err_code), 'h33);
      cfg_default(); probe_reply = 1; probe_val = 8'h33; probe_d = TO + 1;
      run(4, 0, 1, 3, g);
      chk_s("R6", "late byte ignored order", tok_str, "WXCXXS");
      chk_i("R6", "late byte ignored status", int'(status), 0);
   endtask

   task automatic t_crc();
      bit g;
      cfg_default(); crc_bad = 1;
      run(4, 0, 2, 2, g);
      chk_s("R9", "one re-read order", tok_str, "WXCXXXS");
      chk_i("R9", "one re-read status", int'(status), 0);
      cfg_default(); crc_bad = RTY + 1;
      run(4, 0, 2, 2, g);
      chk_s("R9", "exhausted order", tok_str, "WXCXXXXS");
      chk_i("R9", "exhausted status", int'(status), 4);
   endtask

   task automatic t_timeouts();
      bit g;
      cfg_default(); rsp_silent = 1;
      run(4, 0, 2, 2, g);
      chk_s("R10", "silent response order", tok_str, "WXCXXS");
      chk_i("R10", "silent response status", int'(status), 2);
      cfg_default(); sync_silent = 1;
      run(4, 1, 2, 2, g);
      chk_s("R10", "silent wake order", tok_str, "WXS");
      chk_i("R10", "silent wake status", int'(status), 2);
      repeat (6) @(negedge clk);
      chk_i("R11", "status held after done", int'(status), 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      cfg_default();
      t_reset();
      t_normal();
      t_short();
      t_badsync();
      t_probe_err();
      t_probe_edge();
      t_crc();
      t_timeouts();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule